// File: doc/BRIEF.md
# Pipelined Multiplierless FIR Filter

This block is an eight-tap FIR filter with fixed coefficients and no multipliers. Each coefficient is a sum of up to three terms. Each term is the input sample shifted left by a constant and then added or subtracted. The filter uses the transposed form. Every tap folds its shifted terms and the partial sum from the tap above into a carry-save pair, and registers that pair. Only the pair leaving tap 0 is resolved into a binary value, by a single ripple-carry adder cut into four pipeline slices. The low 16 bits of the full-precision result are dropped, and the remaining upper bits form the output sample.

Samples arrive with a valid strobe. Only cycles with the strobe asserted advance the filter history. The output strobe marks each filtered result.

Top module: `fir_shiftadd`

## Requirements
- R1: Each tap coefficient equals the sum of its three terms, sign·2^shift, where sign is +1, -1 or 0 (0 means the term is unused). The full-precision result for the n-th accepted sample is the sum over taps k of coef[k]·x[n-k]. With the default terms the coefficients for taps 0..7 are 8, 30, 316, 1552, 1920, 516, -64 and 28673.
- R2: `out_sample` is the full-precision result arithmetically shifted right by 16, which rounds toward minus infinity. It is a 20-bit two's-complement value.
- R3: A sample taken at a rising edge with `in_valid` high produces its result, with `out_valid` high, right after the sixth rising edge counting that one. `out_valid` is low in every other cycle.
- R4: Cycles with `in_valid` low do not change the filter history, and no output is produced for them.
- R5: The final carry-propagate addition runs in four equal slices, one per pipeline stage. The binary result equals the sum of the tap-0 carry-save pair four cycles earlier.
- R6: A synchronous active-high `rst` clears the history, the carry-save registers and the pipeline. During and after reset `out_valid` is low and `out_sample` is zero, and results in flight are discarded.
- R7: The extreme inputs -32768 and +32767, alone or in long runs, give exact results with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Output result strobe |
| out_sample | output | 20 | Signed filtered sample with the low 16 bits dropped |

## Verification
Every filtered result is due six rising edges after the edge that accepted its sample: one input register, one tap register and four adder slices. The bench drives inputs on the falling edge. For each accepted sample it computes the expected value with its own model and files it under the edge index where the result is due. After every rising edge it compares `out_valid`, and where one is due `out_sample`, at the following falling edge. Any cycle with no result on file must show `out_valid` low. Inside the design, the sum in the last adder slice is compared with the carry-save pair from four cycles before.

// File: rtl/fir_shiftadd.sv
module fir_shiftadd #(
  parameter int DW    = 16,
  parameter int NTAPS = 8,
  parameter int SHW   = 4,
  parameter int DROP  = 16,
  parameter int PP_SH [NTAPS*3] = '{3,0,0, 5,1,0, 8,6,2, 10,9,4, 11,7,0, 9,2,0, 6,0,0, 15,12,0},
  parameter int PP_SG [NTAPS*3] = '{1,0,0, 1,-1,0, 1,1,-1, 1,1,1, 1,-1,0, 1,1,0, -1,0,0, 1,-1,1},
  localparam int RAWW = DW + (1 << SHW) + 1 + $clog2(NTAPS),
  localparam int ACCW = ((RAWW + 3) / 4) * 4,
  localparam int SL   = ACCW / 4,
  localparam int OUTW = ACCW - DROP
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [DW-1:0]   in_sample,
  output logic                   out_valid,
  output logic signed [OUTW-1:0] out_sample
);

  function automatic logic [ACCW-1:0] term(input logic [DW-1:0] x, input int sh, input int sg);
    logic [ACCW-1:0] e;
    e = {{(ACCW-DW){x[DW-1]}}, x} << sh;
    if (sg > 0) return e;
    if (sg < 0) return -e;
    return '0;
  endfunction

  function automatic logic [ACCW-1:0] xor3(input logic [ACCW-1:0] a, b, c);
    return a ^ b ^ c;
  endfunction

  function automatic logic [ACCW-1:0] maj3(input logic [ACCW-1:0] a, b, c);
    return ((a & b) | (a & c) | (b & c)) << 1;
  endfunction

  logic [5:0] vp;
  logic [DW-1:0] x_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      vp  <= '0;
      x_r <= '0;
    end else begin
      vp <= {vp[4:0], in_valid};
      if (in_valid) x_r <= in_sample;
    end
  end

  logic [NTAPS-1:0][ACCW-1:0] ts, tc, ns, nc;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic [ACCW-1:0] a0, a1, a2, ps, pc, s1, c1, s2, c2;
    assign a0 = term(x_r, PP_SH[3*k],   PP_SG[3*k]);
    assign a1 = term(x_r, PP_SH[3*k+1], PP_SG[3*k+1]);
    assign a2 = term(x_r, PP_SH[3*k+2], PP_SG[3*k+2]);
    if (k == NTAPS-1) begin : g_last
      assign ps = '0;
      assign pc = '0;
    end else begin : g_mid
      assign ps = ts[k+1];
      assign pc = tc[k+1];
    end
    assign s1 = xor3(a0, a1, a2);
    assign c1 = maj3(a0, a1, a2);
    assign s2 = xor3(s1, c1, ps);
    assign c2 = maj3(s1, c1, ps);
    assign ns[k] = xor3(s2, c2, pc);
    assign nc[k] = maj3(s2, c2, pc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ts <= '0;
      tc <= '0;
    end else if (vp[0]) begin
      ts <= ns;
      tc <= nc;
    end
  end

  logic [2:0][ACCW-1:0] ra, rb, na, nb;
  logic [3:0][ACCW-1:0] rs, nxs;
  logic [2:0] rc, ncy;

  for (genvar j = 0; j < 4; j++) begin : g_rca
    logic [ACCW-1:0] ai, bi, si;
    logic ci;
    logic [SL:0] p;
    if (j == 0) begin : g_first
      assign ai = ts[0];
      assign bi = tc[0];
      assign si = '0;
      assign ci = 1'b0;
    end else begin : g_next
      assign ai = ra[j-1];
      assign bi = rb[j-1];
      assign si = rs[j-1];
      assign ci = rc[j-1];
    end
    assign p = {1'b0, ai[j*SL +: SL]} + {1'b0, bi[j*SL +: SL]} + {{SL{1'b0}}, ci};
    assign nxs[j] = si | (ACCW'(p[SL-1:0]) << (j*SL));
    if (j < 3) begin : g_fwd
      assign na[j]  = ai;
      assign nb[j]  = bi;
      assign ncy[j] = p[SL];
    end else begin : g_top
      logic unused_carry;
      assign unused_carry = p[SL];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ra <= '0;
      rb <= '0;
      rs <= '0;
      rc <= '0;
    end else begin
      ra <= na;
      rb <= nb;
      rs <= nxs;
      rc <= ncy;
    end
  end

  assign out_sample = rs[3][ACCW-1:DROP];
  assign out_valid  = vp[5];

  logic unused_bits;
  assign unused_bits = ^{ra[2], rb[2], rs[3][DROP-1:0]};

  logic [2:0] age;
  logic [ACCW-1:0] csum0;
  assign csum0 = ts[0] + tc[0];

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  assert_valid_delay_R3: assert property (@(posedge clk) disable iff (rst)
    (age == 3'd7) |-> (out_valid == $past(in_valid, 6)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !vp[0] |=> $stable(csum0));

  assert_rca_sum_R5: assert property (@(posedge clk) disable iff (rst)
    (age == 3'd7) |-> (rs[3] == $past(csum0, 4)));

  assert_reset_clear_R6: assert property (@(posedge clk)
    rst |=> (!out_valid && out_sample == '0));

endmodule

// File: tb/sim_fir_shiftadd.sv
module sim_fir_shiftadd;
  localparam int PERIOD = 10;
  localparam int NT = 8;
  localparam int NV = 24;
  localparam int SH_T [NT*3] = '{3,0,0, 5,1,0, 8,6,2, 10,9,4, 11,7,0, 9,2,0, 6,0,0, 15,12,0};
  localparam int SG_T [NT*3] = '{1,0,0, 1,-1,0, 1,1,-1, 1,1,1, 1,-1,0, 1,1,0, -1,0,0, 1,-1,1};
  localparam int VX [NV] = '{100, -200, 3000, 0, -32768, 32767, 1234, -5678, 0, 0, 777, -1,
                             20000, -20000, 5, 31000, -31000, 42, 0, 16000, -9, 8191, -8192, 300};
  localparam bit VV [NV] = '{1,1,1,0,1,1,1,1,0,1,1,1,0,1,1,1,1,0,1,1,1,1,0,1};

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic out_valid;
  logic signed [19:0] out_sample;

  always #(PERIOD/2) clk = ~clk;

  fir_shiftadd u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
                   .out_valid(out_valid), .out_sample(out_sample));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  string tag = "";
  bit ev [4096];
  longint ey [4096];
  longint hist [NT];

  function automatic longint coef(int k);
    longint c = 0;
    for (int m = 0; m < 3; m++) c += longint'(SG_T[3*k+m]) * (longint'(1) <<< SH_T[3*k+m]);
    return c;
  endfunction

  task automatic check(bit ok, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, int x);
    longint y;
    in_valid = v;
    in_sample = 16'(x);
    if (v) begin
      for (int i = NT-1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = x;
      y = 0;
      for (int k = 0; k < NT; k++) y += coef(k) * hist[k];
      ev[cyc+6] = 1'b1;
      ey[cyc+6] = y >>> 16;
    end
    @(posedge clk);
    cyc++;
    @(negedge clk);
    check(out_valid == ev[cyc], "R3 out_valid", longint'(out_valid), longint'(ev[cyc]));
    if (ev[cyc])
      check(longint'(out_sample) == ey[cyc], "R1 R2 out_sample", longint'(out_sample), ey[cyc]);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    cyc++;
    @(negedge clk);
    check(!out_valid, "R6 out_valid in reset", longint'(out_valid), 0);
    check(out_sample == '0, "R6 out_sample in reset", longint'(out_sample), 0);
    for (int i = 0; i < NT; i++) hist[i] = 0;
    for (int i = cyc; i < cyc + 8; i++) ev[i] = 1'b0;
    rst = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NT; i++) hist[i] = 0;
    @(negedge clk);
    tag = "R6 initial";
    do_reset();

    tag = "R1 R3 R4 table";
    for (int i = 0; i < NV; i++) step(VV[i], VX[i]);

    tag = "R4 idle";
    for (int i = 0; i < 8; i++) step(1'b0, 0);
    step(1'b1, 500);
    for (int i = 0; i < 3; i++) step(1'b0, 12345);
    step(1'b1, -700);

    tag = "R2 rounding";
    step(1'b1, -1);
    step(1'b1, 1);
    step(1'b1, 3);
    step(1'b1, -3);

    tag = "R7 impulse";
    step(1'b1, -32768);
    for (int i = 0; i < 8; i++) step(1'b1, 0);
    tag = "R7 max run";
    for (int i = 0; i < 10; i++) step(1'b1, 32767);
    tag = "R7 min run";
    for (int i = 0; i < 10; i++) step(1'b1, -32768);

    tag = "R5 carry";
    for (int i = 0; i < 12; i++) step(1'b1, (i % 2) ? -32768 : 32767);
    for (int i = 0; i < 6; i++) step(1'b1, (i % 3 == 0) ? -1 : 1);

    tag = "R6 midstream";
    step(1'b1, 9000);
    step(1'b1, -9000);
    step(1'b1, 4000);
    do_reset();
    for (int i = 0; i < 8; i++) step(1'b0, 0);
    for (int i = 0; i < 9; i++) step(1'b1, 1000);

    tag = "drain";
    for (int i = 0; i < 8; i++) step(1'b0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule